// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that needs no idle cycle when the bus changes direction. The block registers the address and the command on one rising clock edge. The data for that command moves in the following cycle. A write takes its data in the next cycle. A read drives its word straight from the array during the next cycle, with no output register. Because of this one-cycle split, a caller can issue a read, then a write, then a read again on consecutive edges with no gap.

A load strobe chooses between two kinds of cycle. In a load cycle the block takes a new address and direction. In an advance cycle an internal four-word burst counter steps, and the block ignores the external address and the direction input. Burst order is linear or interleaved. Only the two low address bits step. Three chip enables of mixed polarity qualify each load. A clock-enable input can suspend the whole block for any number of edges. An asynchronous output enable gates the read drive. The data bus is split into an input port, an output port and a drive-enable output, so an outer level can build the shared pins.

Top module: `pipe_sram`

## Requirements
- R1: When a selected load read is taken on an edge, `rdata` carries the stored word at the loaded address during the next cycle, and `rdata_oe` is high in that cycle (given `out_en_n` low). No further edge is needed.
- R2: A selected load write stores `wdata`, as presented in the cycle after the load, at the edge that closes that cycle. Reads and writes may alternate on every edge with no idle cycle, and every word reads back as written.
- R3: Byte lane k is `wdata[9k+8:9k]`. The lane is written only when `byte_we_n[k]` was low on the edge that set up the write. Lanes whose enable was high keep their old contents. Byte enables have no effect on read cycles.
- R4: The block is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load with any other combination is a deselect. In the next cycle `rdata_oe` is low, nothing is written, and any burst in progress ends.
- R5: A read or write that was pending when a deselect is loaded still completes. The read word is driven during the deselect cycle, and the write data of that cycle is stored.
- R6: In the data cycle of a write, `rdata_oe` is low.
- R7: An advance (`ld_n`=1) during an active burst sets up the next beat with the direction latched at the load. The beat ignores `addr` and `we_n`, and it samples `byte_we_n` afresh.
- R8: Beat i of a burst (i = 0 at the load) uses the loaded upper address bits. Its two low bits are (base+i) mod 4 when `order_il` was 0 at the load, and base XOR (i mod 4) when it was 1. The sequence wraps after four beats and keeps going.
- R9: An advance when no burst is active (after reset or after a deselect) is a no-operation. `rdata_oe` stays low in the next cycle, and nothing is written.
- R10: An edge with `clk_en_n`=1 has no effect. No state changes and no write occurs, and `rdata` and `rdata_oe` keep their values.
- R11: `out_en_n`=1 forces `rdata_oe` low at once, without waiting for an edge. Returning it to 0 restores the drive of a pending read.
- R12: Asserting `rst_n` low clears the pending operation to no-operation at once. `rdata_oe` then drops, and no burst is active afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | High blocks the current edge completely |
| ld_n | input | 1 | Low: load new address and command; high: advance burst |
| we_n | input | 1 | Direction at a load: 1 read, 0 write |
| addr | input | ADDR_W | Word address, used on load cycles only |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| byte_we_n | input | 4 | Per-lane write enables, active low |
| order_il | input | 1 | Burst order at a load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, presented in the data cycle |
| rdata | output | 36 | Flow-through read data |
| rdata_oe | output | 1 | Drive enable for `rdata` |

## Verification
The bench goes after the one-cycle split between command and data. A design that registered the read word would deliver it one cycle late. A design that wrote at the command edge would store the wrong cycle's data, and back-to-back write-then-read sequences expose both errors. All eight chip-enable combinations are swept with a read pending, so a design that cancelled the pending transfer on deselect, or decoded a polarity wrongly, loses the word. Bursts are run from every start offset in both orders and both directions, for six beats, with random address and direction inputs during the advance cycles. A design that wrapped badly, honoured those inputs, or read the order pin live would show it. Suspended edges, asynchronous output-enable and reset pulses, and a long random mix round this out.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_burst_ctr.sv
// Burst sequencer: latches base address, direction and order on a load,
// produces the address and operation for the command being set up.
module sram_burst_ctr
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              stop,
  input  logic              advance,
  input  logic              wr_in,
  input  logic              order_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] next_addr,
  output sram_op_e          next_op
);
  localparam int LOW_W = 2;

  logic              live_q, live_d;
  logic              wr_q, wr_d;
  logic              il_q, il_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LOW_W-1:0]  cnt_q, cnt_d;
  logic [LOW_W-1:0]  cnt_inc;
  logic [LOW_W-1:0]  low_step;

  always_comb begin
    cnt_inc  = cnt_q + LOW_W'(1);
    low_step = il_q ? (base_q[LOW_W-1:0] ^ cnt_inc)
                    : (base_q[LOW_W-1:0] + cnt_inc);
    if (load) begin
      next_addr = addr_in;
      next_op   = wr_in ? OP_WRITE : OP_READ;
    end else if (advance && live_q) begin
      next_addr = {base_q[ADDR_W-1:LOW_W], low_step};
      next_op   = wr_q ? OP_WRITE : OP_READ;
    end else begin
      next_addr = base_q;
      next_op   = OP_IDLE;
    end
  end

  always_comb begin
    live_d = live_q;
    wr_d   = wr_q;
    il_d   = il_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (en) begin
      if (load) begin
        live_d = 1'b1;
        wr_d   = wr_in;
        il_d   = order_in;
        base_d = addr_in;
        cnt_d  = '0;
      end else if (stop) begin
        live_d = 1'b0;
      end else if (advance && live_q) begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      wr_q   <= 1'b0;
      il_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      live_q <= live_d;
      wr_q   <= wr_d;
      il_q   <= il_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_ctrl_pipe.sv
// Command stage: holds the operation whose data moves in the current cycle.
module sram_ctrl_pipe
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  sram_op_e          op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BYTES-1:0]  bwe_n_in,
  output sram_op_e          pend_op,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [BYTES-1:0]  pend_bwe_n
);
  sram_op_e          op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BYTES-1:0]  bwe_d;

  always_comb begin
    op_d   = pend_op;
    addr_d = pend_addr;
    bwe_d  = pend_bwe_n;
    if (en) begin
      op_d   = op_in;
      addr_d = addr_in;
      bwe_d  = bwe_n_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op    <= OP_IDLE;
      pend_addr  <= '0;
      pend_bwe_n <= '1;
    end else begin
      pend_op    <= op_d;
      pend_addr  <= addr_d;
      pend_bwe_n <= bwe_d;
    end
  end
endmodule

// File: rtl/sram_array.sv
// Storage: one array per byte lane, flow-through read.
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES-1:0]        bwe_n,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !bwe_n[k]) begin
        mem[addr] <= wdata[k*BYTE_W +: BYTE_W];
      end
    end

    assign rdata[k*BYTE_W +: BYTE_W] = mem[addr];
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    ld_n,
  input  logic                    we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic [BYTES-1:0]        byte_we_n,
  input  logic                    order_il,
  input  logic                    out_en_n,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    rdata_oe
);
  logic              en;
  logic              chip_sel;
  logic              do_load;
  logic              do_stop;
  logic              do_adv;
  logic [ADDR_W-1:0] cmd_addr;
  sram_op_e          cmd_op;
  sram_op_e          pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [BYTES-1:0]  pend_bwe_n;

  assign en       = ~clk_en_n;
  assign chip_sel = ~sel_a_n & ~sel_b_n & sel_c;
  assign do_load  = ~ld_n & chip_sel;
  assign do_stop  = ~ld_n & ~chip_sel;
  assign do_adv   = ld_n;

  sram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (do_load),
    .stop     (do_stop),
    .advance  (do_adv),
    .wr_in    (~we_n),
    .order_in (order_il),
    .addr_in  (addr),
    .next_addr(cmd_addr),
    .next_op  (cmd_op)
  );

  sram_ctrl_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .op_in     (cmd_op),
    .addr_in   (cmd_addr),
    .bwe_n_in  (byte_we_n),
    .pend_op   (pend_op),
    .pend_addr (pend_addr),
    .pend_bwe_n(pend_bwe_n)
  );

  sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk  (clk),
    .wr_en(en && (pend_op == OP_WRITE)),
    .addr (pend_addr),
    .bwe_n(pend_bwe_n),
    .wdata(wdata),
    .rdata(rdata)
  );

  assign rdata_oe = (pend_op == OP_READ) && !out_en_n;
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              ld_n,
  input logic              we_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              out_en_n,
  input logic              rdata_oe,
  input logic [1:0]        pend_op,
  input logic [ADDR_W-1:0] pend_addr
);
  logic sel_ok;
  assign sel_ok = !sel_a_n && !sel_b_n && sel_c;

  AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe); // R11
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(pend_op) && $stable(pend_addr))); // R10
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && !sel_ok) |=> (pend_op == OP_IDLE)); // R4
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && sel_ok && !we_n) |=> !rdata_oe); // R6
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && sel_ok && we_n) |=> (rdata_oe == !out_en_n)); // R1
  AST_BURST_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ld_n && pend_op != OP_IDLE) |=> (pend_op == $past(pend_op))); // R7
  AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ld_n && pend_op != OP_IDLE)
      |=> (pend_addr[ADDR_W-1:2] == $past(pend_addr[ADDR_W-1:2]))); // R8
  AST_NOOP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ld_n && pend_op == OP_IDLE) |=> (pend_op == OP_IDLE)); // R9
endmodule

bind pipe_sram pipe_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .ld_n     (ld_n),
  .we_n     (we_n),
  .sel_a_n  (sel_a_n),
  .sel_b_n  (sel_b_n),
  .sel_c    (sel_c),
  .out_en_n (out_en_n),
  .rdata_oe (rdata_oe),
  .pend_op  (pend_op),
  .pend_addr(pend_addr)
);

// File: tb/pipe_sram_tb.sv
module pipe_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n, clk_en_n, ld_n, we_n, sel_a_n, sel_b_n, sel_c, order_il, out_en_n;
  logic [AW-1:0] addr;
  logic [3:0]    byte_we_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench-side expectation state
  logic [DW-1:0] mem_m [64];
  int            m_op;        // 0 none, 1 read, 2 write
  logic [AW-1:0] m_addr;
  logic [3:0]    m_bwe;
  string         m_tag;
  bit            b_live, b_wr, b_il;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  bit            prev_susp;

  pipe_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ld_n(ld_n), .we_n(we_n),
    .addr(addr), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .byte_we_n(byte_we_n), .order_il(order_il), .out_en_n(out_en_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int n);
    return DW'(n * 36'h0_9E37_79B9) ^ 36'hA_5A5A_5A5A;
  endfunction

  task automatic model_reset();
    m_op = 0; b_live = 0; prev_susp = 0; m_tag = "R12";
  endtask

  // One bus cycle: drive, check the pending transfer, then take the edge.
  task automatic cyc(input bit ce_n, input bit ld, input bit wn, input logic [AW-1:0] a,
                     input logic [2:0] sel, input logic [3:0] bwe, input bit il,
                     input logic [DW-1:0] wd, input bit oen, input string tag);
    bit            exp_oe;
    bit            selected;
    logic [1:0]    nc;
    logic [1:0]    lo;
    string         use_tag;
    @(negedge clk);
    clk_en_n = ce_n; ld_n = ld; we_n = wn; addr = a;
    sel_a_n = sel[2]; sel_b_n = sel[1]; sel_c = sel[0];
    byte_we_n = bwe; order_il = il; wdata = wd; out_en_n = oen;
    #3;
    use_tag = prev_susp ? "R10" : m_tag;
    exp_oe = (m_op == 1) && !oen;
    chk(rdata_oe === exp_oe, use_tag, DW'(rdata_oe), DW'(exp_oe));
    if (m_op == 1) chk(rdata === mem_m[m_addr], use_tag, rdata, mem_m[m_addr]);
    if (!ce_n) begin
      if (m_op == 2)
        for (int k = 0; k < 4; k++)
          if (!m_bwe[k]) mem_m[m_addr][9*k +: 9] = wd[9*k +: 9];
      selected = (sel == 3'b001);
      if (!ld) begin
        if (selected) begin
          m_op = wn ? 1 : 2; m_addr = a; m_bwe = bwe;
          b_live = 1; b_base = a; b_cnt = 0; b_wr = !wn; b_il = il;
        end else begin
          m_op = 0; b_live = 0;
        end
      end else if (b_live) begin
        nc = b_cnt + 2'd1; b_cnt = nc;
        lo = b_il ? (b_base[1:0] ^ nc) : (b_base[1:0] + nc);
        m_addr = {b_base[AW-1:2], lo};
        m_op = b_wr ? 2 : 1; m_bwe = bwe;
      end else begin
        m_op = 0;
      end
      m_tag = tag;
    end
    prev_susp = ce_n;
    @(posedge clk);
  endtask

  // deselect cycle with write data for a pending write
  task automatic desel(input logic [DW-1:0] wd, input string tag);
    cyc(0, 0, 1, '0, 3'b000, 4'hF, 0, wd, 0, tag);
  endtask

  initial begin : watchdog
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; clk_en_n = 0; ld_n = 1; we_n = 1; addr = '0;
    sel_a_n = 1; sel_b_n = 1; sel_c = 0; byte_we_n = '1; order_il = 0;
    out_en_n = 0; wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    chk(rdata_oe === 1'b0, "R12", DW'(rdata_oe), '0);   // R12 reset state
    @(negedge clk); rst_n = 1;

    // R9: advance right after reset is a no-operation
    cyc(0, 1, 0, 6'd5, 3'b001, 4'h0, 0, '0, 0, "R9");
    cyc(0, 1, 1, 6'd5, 3'b001, 4'h0, 0, '0, 0, "R9");

    // R2/R6: fill every word with back-to-back writes
    for (int a = 0; a < 64; a++)
      cyc(0, 0, 0, AW'(a), 3'b001, 4'h0, 0, (a == 0) ? '0 : pat(a - 1), 0, "R6");
    desel(pat(63), "R4");
    // R2: read all back with back-to-back loads
    for (int a = 0; a < 64; a++)
      cyc(0, 0, 1, AW'(a), 3'b001, 4'($urandom), 0, '0, 0, "R2");
    desel('0, "R2");

    // R1/R2: alternating write/read with no idle cycle, read-after-write same word
    for (int a = 0; a < 16; a++) begin
      cyc(0, 0, 0, AW'(a), 3'b001, 4'h0, 0, '0, 0, "R6");
      cyc(0, 0, 1, AW'(a), 3'b001, 4'h0, 0, pat(a + 100), 0, "R1");
      cyc(0, 0, 1, AW'(a + 1), 3'b001, 4'h0, 0, '0, 0, "R1");
    end
    desel('0, "R1");

    // R3: every byte-enable pattern
    for (int p = 0; p < 16; p++) begin
      cyc(0, 0, 0, AW'(16 + p), 3'b001, 4'(p), 0, '0, 0, "R6");
      cyc(0, 0, 1, AW'(16 + p), 3'b001, 4'(~p), 0, ~pat(p + 7), 0, "R3");
    end
    desel('0, "R3");

    // R7/R8: bursts from every start offset, both orders, both directions
    for (int wr = 0; wr < 2; wr++)
      for (int il = 0; il < 2; il++)
        for (int b = 0; b < 4; b++) begin
          logic [AW-1:0] base;
          base = AW'(40 + b + 4 * (il + 2 * wr) % 20);
          if (wr == 1) begin
            cyc(0, 0, 0, base, 3'b001, 4'h0, il[0], '0, 0, "R7");
            for (int i = 0; i < 6; i++)
              cyc(0, 1, 1'($urandom), AW'($urandom), 3'($urandom), 4'($urandom), 1'($urandom),
                  pat(1000 + i + 8 * b), 0, "R7");
            desel(pat(2000 + b), "R7");
          end
          cyc(0, 0, 1, base, 3'b001, 4'h0, il[0], '0, 0, "R8");
          for (int i = 0; i < 6; i++)
            cyc(0, 1, 1'($urandom), AW'($urandom), 3'($urandom), 4'($urandom), ~il[0],
                '0, 0, "R8");
          desel('0, "R8");
        end

    // R4/R5/R9: every chip-enable combination, with a read or write pending
    for (int s = 0; s < 8; s++) begin
      if (s == 1) continue;
      cyc(0, 0, 1, AW'(s), 3'b001, 4'h0, 0, '0, 0, "R5");
      cyc(0, 0, 1, AW'(s + 9), 3'(s), 4'h0, 0, '0, 0, "R4");
      cyc(0, 1, 1, AW'(s + 9), 3'b001, 4'h0, 0, '0, 0, "R9");
      cyc(0, 0, 0, AW'(s + 48), 3'b001, 4'h0, 0, '0, 0, "R6");
      cyc(0, 0, 0, AW'(s), 3'(s), 4'h0, 0, pat(s + 300), 0, "R4");
      cyc(0, 1, 0, AW'(s), 3'b001, 4'h0, 0, pat(s + 400), 0, "R9");
      cyc(0, 0, 1, AW'(s + 48), 3'b001, 4'h0, 0, pat(s + 500), 0, "R5");
      desel('0, "R5");
    end

    // R10: suspended edges hold a read and a write
    cyc(0, 0, 1, 6'd20, 3'b001, 4'h0, 0, '0, 0, "R1");
    cyc(1, 0, 0, 6'd33, 3'b001, 4'h0, 0, '1, 0, "R10");
    cyc(1, 0, 0, 6'd34, 3'b000, 4'h0, 1, '1, 0, "R10");
    cyc(0, 0, 0, 6'd21, 3'b001, 4'h0, 0, '0, 0, "R6");
    cyc(1, 1, 1, 6'd22, 3'b000, 4'h0, 0, pat(900), 0, "R10");
    cyc(0, 0, 1, 6'd21, 3'b001, 4'h0, 0, pat(901), 0, "R10");
    desel('0, "R10");

    // R11/R12: asynchronous output enable and reset within a cycle
    cyc(0, 0, 1, 6'd3, 3'b001, 4'h0, 0, '0, 0, "R1");
    @(negedge clk);
    ld_n = 0; sel_a_n = 1;
    #1 chk(rdata_oe === 1'b1, "R11", DW'(rdata_oe), 36'd1);
    out_en_n = 1;
    #1 chk(rdata_oe === 1'b0, "R11", DW'(rdata_oe), '0);
    out_en_n = 0;
    #1 chk(rdata_oe === 1'b1, "R11", DW'(rdata_oe), 36'd1);
    rst_n = 0;
    #1 chk(rdata_oe === 1'b0, "R12", DW'(rdata_oe), '0);
    @(posedge clk);
    @(negedge clk); rst_n = 1;
    model_reset();
    cyc(0, 1, 1, 6'd3, 3'b001, 4'h0, 0, '0, 0, "R12");
    cyc(0, 1, 1, 6'd3, 3'b001, 4'h0, 0, '0, 0, "R12");

    // R2: long random mix of loads, advances, deselects, suspends
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      cyc(($urandom % 8) == 0, ($urandom % 3) == 0, 1'($urandom), AW'($urandom),
          (($urandom % 6) == 0) ? 3'($urandom) : 3'b001, 4'($urandom), 1'($urandom),
          r[DW-1:0], ($urandom % 10) == 0, "R2");
    end
    desel('0, "R2");

    // final readback of the whole array
    for (int a = 0; a < 64; a++)
      cyc(0, 0, 1, AW'(a), 3'b001, 4'h0, 0, '0, 0, "R2");
    desel('0, "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule